// File: doc/BRIEF.md
# NAND Host Mode-Register Bus Bridge

This block connects a 16-bit register bus to an 8-bit raw NAND flash device. Software first writes a code to a mode register. Bits of that code drive the NAND chip-enable, command-latch and address-latch lines directly. Software then moves bytes through a data port. A status register reports whether the device's ready/busy input shows busy. Further bits of the mode register (write-protect release, two ECC control bits and two power control bits) are held, driven out on pins and readable.

A 16-bit data-port access becomes two NAND byte cycles: low byte first, then high byte. An 8-bit access becomes one cycle on the low byte. Each byte cycle pulls the read or write strobe low for a fixed, parameterised number of clocks and follows it with one recovery clock. The bus access stalls until the last cycle has finished. The phase (command, address or data) comes from the whole code written to the mode register. A typical sequence is: write the command-phase code, write 0xFF to the data port to reset the device, then return to data phase.

Top module: `nand_mode_bridge`

## Requirements
- R1: After reset the mode register holds 0x00. Outputs: nand_ce_n=1, nand_cle=0, nand_ale=0, nand_we_n=1, nand_re_n=1, nand_io_oe=0, bus_busy=0, bus_done=0.
- R2: Mode register at bus address 1. Writing 0x94 selects data phase (nand_ce_n=0, cle=0, ale=0). Writing 0x95 selects command phase (cle=1). Writing 0x96 selects address phase (ale=1). A read of address 1 returns the low byte last written, with bits 15:8 zero.
- R3: Mode bit positions: bit0 drives nand_cle, bit1 drives nand_ale, bits 3:2 drive ctl_pwr, bit4 set drives nand_ce_n low, bits 6:5 drive ctl_ecc, bit7 drives nand_wp_n. All are held until the next mode write.
- R4: Writing mode 0x00 gives standby: nand_ce_n=1, cle=0, ale=0.
- R5: Status register at bus address 2. Bit 7 reads 1 while nand_rb_n is low (busy) and 0 while it is high. All other bits read 0.
- R6: A 16-bit read of the data port (address 0, bus_wide=1) performs two NAND byte reads. The first byte read is returned in bits 7:0 and the second in bits 15:8.
- R7: A 16-bit write of the data port drives bus_wdata[7:0] in the first NAND write cycle and bus_wdata[15:8] in the second.
- R8: An 8-bit data-port access (bus_wide=0) performs exactly one NAND byte cycle on the low byte. A read returns that byte in bits 7:0 with bits 15:8 zero.
- R9: Each byte cycle holds exactly one strobe low for exactly STROBE_CLKS clocks, followed by at least one clock with both strobes high. nand_io_oe is never high while nand_re_n is low.
- R10: Take the edge that accepts a data-port request as edge 0. bus_done rises at edge STROBE_CLKS+1 for one byte and at edge 2*STROBE_CLKS+2 for two bytes. bus_busy is high in between, and any request made while bus_busy is high is ignored.
- R11: In command phase, an 8-bit data-port write of 0xFF produces a single NAND write cycle with nand_cle=1 and nand_ale=0, carrying 0xFF. In address phase the cycle carries nand_ale=1 instead.
- R12: A mode or status access completes with bus_done rising at the accepting edge (edge 0). A write returns rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, accepted on a clock edge where bus_busy is low |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data port, 1 mode, 2 status, 3 reads zero |
| bus_wide | input | 1 | Data port: 1 = 16-bit (two bytes), 0 = 8-bit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_done is high |
| bus_done | output | 1 | One-cycle completion pulse |
| bus_busy | output | 1 | A NAND byte transfer is in progress |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write-protect release (mode bit 7) |
| ctl_ecc | output | 2 | Held ECC control bits |
| ctl_pwr | output | 2 | Held power control bits |
| nand_io_out | output | 8 | Byte driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte from the device |
| nand_rb_n | input | 1 | Ready/busy from device, low = busy |

## Verification
A wrong lane index in the sequencer would show up on the device side: the log of written bytes would be out of order. It would also show up on the bus side, where the halves of a returned word would be swapped. Both are visible as soon as the access completes. A strobe counter that is off by one moves bus_done by one or two edges, so every timed access exposes it, and the strobe-width check flags it at the first rising strobe. A mode register that loads while a transfer is in flight changes the latch or chip-enable pins in the middle of a transfer. This is caught one cycle after the stray request, and again when the mode register is read back.

// File: rtl/nmb_pkg.sv
`timescale 1ns/1ps
package nmb_pkg;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_MODE = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_RSVD = 2'd3
  } bus_addr_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_STROBE = 2'd1,
    SQ_RECOV  = 2'd2
  } seq_state_e;

  // mode register bit positions
  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_PWR = 2;  // two bits
  localparam int MB_CE  = 4;
  localparam int MB_ECC = 5;  // two bits
  localparam int MB_WP  = 7;

  localparam int STAT_BUSY_BIT = 7;

  function automatic logic [15:0] status_word(input logic busy);
    logic [15:0] w;
    w = '0;
    w[STAT_BUSY_BIT] = busy;
    return w;
  endfunction

  function automatic logic [15:0] mode_word(input logic [7:0] m);
    return {8'h00, m};
  endfunction

endpackage

// File: rtl/nmb_mode_reg.sv
`timescale 1ns/1ps
module nmb_mode_reg
  import nmb_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_byte,
  output logic [MODE_W-1:0] mode_q,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              wp_n,
  output logic [1:0]        ecc,
  output logic [1:0]        pwr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= '0;
    else if (wr_en) mode_q <= wr_byte;
  end

  assign cle  = mode_q[MB_CLE];
  assign ale  = mode_q[MB_ALE];
  assign ce_n = ~mode_q[MB_CE];
  assign wp_n = mode_q[MB_WP];
  assign ecc  = mode_q[MB_ECC +: 2];
  assign pwr  = mode_q[MB_PWR +: 2];

  // R2 / R3: a mode write shows on the phase pins in the next cycle
  assert_mode_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cle == $past(wr_byte[MB_CLE]) && ale == $past(wr_byte[MB_ALE])
               && ce_n == !$past(wr_byte[MB_CE])));

endmodule

// File: rtl/nmb_byte_seq.sv
`timescale 1ns/1ps
module nmb_byte_seq
  import nmb_pkg::*;
#(
  parameter int STROBE_CLKS = 3,
  parameter int BYTE_W      = 8,
  parameter int LANES       = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    wr,
  input  logic                    two,
  input  logic [BYTE_W*LANES-1:0] wdata,
  output logic                    busy,
  output logic                    finish,
  output logic [BYTE_W*LANES-1:0] word,
  output logic                    we_n,
  output logic                    re_n,
  output logic [BYTE_W-1:0]       io_out,
  output logic                    io_oe,
  input  logic [BYTE_W-1:0]       io_in
);

  localparam int CW     = $clog2(STROBE_CLKS + 1);
  localparam int IW     = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int WORD_W = BYTE_W * LANES;
  localparam logic [CW-1:0] CNT_LAST  = CW'(STROBE_CLKS - 1);
  localparam logic [IW-1:0] LANE_LAST = IW'(LANES - 1);

  seq_state_e        state_q;
  logic [CW-1:0]     cnt_q;
  logic [IW-1:0]     idx_q;
  logic [IW-1:0]     last_q;
  logic              wr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] word_q;

  // named internal events
  logic strobe_end;
  logic lane_last;
  assign strobe_end = (state_q == SQ_STROBE) && (cnt_q == CNT_LAST);
  assign lane_last  = (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      word_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_STROBE;
          cnt_q   <= '0;
          idx_q   <= '0;
          last_q  <= two ? LANE_LAST : '0;
          wr_q    <= wr;
          wdata_q <= wdata;
          word_q  <= '0;
        end
        SQ_STROBE: begin
          if (strobe_end) begin
            state_q <= SQ_RECOV;
            if (!wr_q) word_q[idx_q*BYTE_W +: BYTE_W] <= io_in;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_RECOV: begin
          if (lane_last) begin
            state_q <= SQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            cnt_q   <= '0;
            state_q <= SQ_STROBE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != SQ_IDLE);
  assign finish = (state_q == SQ_RECOV) && lane_last;
  assign word   = word_q;
  assign we_n   = !((state_q == SQ_STROBE) && wr_q);
  assign re_n   = !((state_q == SQ_STROBE) && !wr_q);
  assign io_oe  = wr_q && busy;
  assign io_out = wdata_q[idx_q*BYTE_W +: BYTE_W];

  // checker: independent count of consecutive low-strobe cycles
  logic          strobe_lo;
  logic [CW-1:0] low_run;
  assign strobe_lo = !we_n || !re_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (strobe_lo) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  assert_strobe_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_lo) |-> ($past(low_run) == CNT_LAST));

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);

endmodule

// File: rtl/nand_mode_bridge.sv
`timescale 1ns/1ps
module nand_mode_bridge
  import nmb_pkg::*;
#(
  parameter int STROBE_CLKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wide,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_done,
  output logic        bus_busy,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_wp_n,
  output logic [1:0]  ctl_ecc,
  output logic [1:0]  ctl_pwr,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb_n
);

  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  logic              seq_busy;
  logic              seq_finish;
  logic [WORD_W-1:0] seq_word;
  logic [BYTE_W-1:0] mode_q;

  // named bus events
  logic accept;
  logic data_start;
  logic mode_load;
  logic reg_access;
  assign accept     = bus_req && !seq_busy;
  assign data_start = accept && (bus_addr == ADDR_DATA);
  assign reg_access = accept && (bus_addr != ADDR_DATA);
  assign mode_load  = reg_access && bus_wr && (bus_addr == ADDR_MODE);

  nmb_mode_reg #(.MODE_W(BYTE_W)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_load),
    .wr_byte (bus_wdata[BYTE_W-1:0]),
    .mode_q  (mode_q),
    .ce_n    (nand_ce_n),
    .cle     (nand_cle),
    .ale     (nand_ale),
    .wp_n    (nand_wp_n),
    .ecc     (ctl_ecc),
    .pwr     (ctl_pwr)
  );

  nmb_byte_seq #(
    .STROBE_CLKS (STROBE_CLKS),
    .BYTE_W      (BYTE_W),
    .LANES       (LANES)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (data_start),
    .wr     (bus_wr),
    .two    (bus_wide),
    .wdata  (bus_wdata),
    .busy   (seq_busy),
    .finish (seq_finish),
    .word   (seq_word),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .io_out (nand_io_out),
    .io_oe  (nand_io_oe),
    .io_in  (nand_io_in)
  );

  logic [WORD_W-1:0] reg_rd;
  always_comb begin
    case (bus_addr)
      ADDR_MODE: reg_rd = mode_word(mode_q);
      ADDR_STAT: reg_rd = status_word(!nand_rb_n);
      default:   reg_rd = '0;
    endcase
  end

  logic [WORD_W-1:0] rdata_q;
  logic              done_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (reg_access) begin
        done_q  <= 1'b1;
        rdata_q <= bus_wr ? '0 : reg_rd;
      end else if (seq_finish) begin
        done_q  <= 1'b1;
        rdata_q <= seq_word;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_done  = done_q;
  assign bus_busy  = seq_busy;

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_busy) |=> $stable({nand_ce_n, nand_cle, nand_ale, nand_wp_n}));

  assert_reg_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_busy && bus_addr != ADDR_DATA) |=> bus_done);

  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_busy && bus_addr == ADDR_DATA) |=> (bus_busy && !bus_done));

endmodule

// File: tb/nand_mode_bridge_test.sv
`timescale 1ns/1ps
module nand_mode_bridge_test;

  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wide = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        bus_done, bus_busy;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n;
  logic [1:0]  ctl_ecc, ctl_pwr;
  logic [7:0]  nand_io_out;
  logic        nand_io_oe;
  logic [7:0]  nand_io_in;
  logic        nand_rb_n = 1'b1;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  nand_mode_bridge #(.STROBE_CLKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_busy(bus_busy),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
    .ctl_ecc(ctl_ecc), .ctl_pwr(ctl_pwr), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  // device model: read bytes follow a fixed pattern, writes are logged
  function automatic logic [7:0] dev_byte(input int i);
    return 8'(8'h3C + i * 8'h17);
  endfunction

  int          rd_ptr = 0;
  int          wcount = 0;
  logic [9:0]  wlog [16];

  assign nand_io_in = dev_byte(rd_ptr);

  always @(posedge nand_re_n) if (rst_n) rd_ptr <= rd_ptr + 1;
  always @(posedge nand_we_n) if (rst_n) begin
    wlog[wcount % 16] <= {nand_cle, nand_ale, nand_io_out};
    wcount <= wcount + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one bus access; lat = edges after the accepting edge until bus_done seen
  task automatic bus_op(input logic wr, input logic [1:0] addr, input logic wide,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wide = wide; bus_wdata = wd;
    @(posedge clk); #1;
    bus_req = 1'b0;
    lat = 0;
    while (!bus_done && lat < 100) begin
      @(posedge clk); #1;
      lat++;
    end
    rd = bus_rdata;
  endtask

  // table: {mode code, ce_n, cle, ale, wp_n, ecc[1:0], pwr[1:0]}
  localparam logic [15:0] VEC [6] = '{
    {8'h94, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01},
    {8'h95, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 2'b01},
    {8'h96, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 2'b01},
    {8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00},
    {8'h6C, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11},
    {8'hE8, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 2'b10}
  };

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int lat, p0, w0;

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pins", {nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, bus_busy, bus_done},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
    rst_n = 1'b1;
    bus_op(1'b0, 2'd1, 1'b0, 16'h0, rd, lat);
    chk("R1 mode after reset", rd, 16'h0000);

    // R2 R3 R4 table of mode codes
    for (int i = 0; i < 6; i++) begin
      bus_op(1'b1, 2'd1, 1'b0, {8'hA5, VEC[i][15:8]}, rd, lat);
      chk("R12 write latency", lat, 0);
      chk("R3 pins", {nand_ce_n, nand_cle, nand_ale, nand_wp_n, ctl_ecc, ctl_pwr}, VEC[i][7:0]);
      bus_op(1'b0, 2'd1, 1'b0, 16'h0, rd, lat);
      chk("R2 readback", rd, {8'h00, VEC[i][15:8]});
    end

    // R5 status
    nand_rb_n = 1'b0;
    bus_op(1'b0, 2'd2, 1'b0, 16'h0, rd, lat);
    chk("R5 busy", rd, 16'h0080);
    nand_rb_n = 1'b1;
    bus_op(1'b0, 2'd2, 1'b0, 16'h0, rd, lat);
    chk("R5 ready", rd, 16'h0000);

    // R11 command phase reset code
    bus_op(1'b1, 2'd1, 1'b0, 16'h0095, rd, lat);
    w0 = wcount;
    bus_op(1'b1, 2'd0, 1'b0, 16'h77FF, rd, lat);
    chk("R11 cmd cycles", wcount - w0, 1);
    chk("R11 cmd byte", wlog[w0 % 16], {1'b1, 1'b0, 8'hFF});
    chk("R10 one-byte latency", lat, N + 1);

    // R11 address phase
    bus_op(1'b1, 2'd1, 1'b0, 16'h0096, rd, lat);
    w0 = wcount;
    bus_op(1'b1, 2'd0, 1'b0, 16'h0012, rd, lat);
    chk("R11 addr byte", wlog[w0 % 16], {1'b0, 1'b1, 8'h12});

    // R7 16-bit write order in data phase
    bus_op(1'b1, 2'd1, 1'b0, 16'h0094, rd, lat);
    w0 = wcount;
    bus_op(1'b1, 2'd0, 1'b1, 16'hBEEF, rd, lat);
    chk("R7 cycles", wcount - w0, 2);
    chk("R7 first", wlog[w0 % 16], {2'b00, 8'hEF});
    chk("R7 second", wlog[(w0 + 1) % 16], {2'b00, 8'hBE});
    chk("R10 two-byte latency", lat, 2 * N + 2);

    // R6 16-bit read
    p0 = rd_ptr;
    bus_op(1'b0, 2'd0, 1'b1, 16'h0, rd, lat);
    chk("R6 word", rd, {dev_byte(p0 + 1), dev_byte(p0)});
    chk("R6 reads", rd_ptr - p0, 2);

    // R8 8-bit read
    p0 = rd_ptr;
    bus_op(1'b0, 2'd0, 1'b0, 16'h0, rd, lat);
    chk("R8 byte", rd, {8'h00, dev_byte(p0)});
    chk("R8 reads", rd_ptr - p0, 1);

    // R9 strobe width measured at the pin during a one-byte read
    begin
      int lowc;
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wide = 1'b0;
      @(posedge clk); #1;
      bus_req = 1'b0;
      lowc = 0;
      for (int k = 0; k < N + 4; k++) begin
        if (!nand_re_n) lowc++;
        @(posedge clk); #1;
      end
      chk("R9 strobe width", lowc, N);
    end

    // R10 request during busy is ignored
    w0 = wcount;
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wide = 1'b1; bus_wdata = 16'h1234;
    @(negedge clk);
    bus_addr = 2'd1; bus_wide = 1'b0; bus_wdata = 16'h0000;
    @(negedge clk);
    @(negedge clk);
    bus_req = 1'b0;
    while (!bus_done) @(negedge clk);
    chk("R10 ignored ce_n", nand_ce_n, 1'b0);
    bus_op(1'b0, 2'd1, 1'b0, 16'h0, rd, lat);
    chk("R10 mode kept", rd, 16'h0094);
    chk("R10 cycles", wcount - w0, 2);

    // R4 standby at end
    bus_op(1'b1, 2'd1, 1'b0, 16'h0000, rd, lat);
    chk("R4 standby", {nand_ce_n, nand_cle, nand_ale}, 3'b100);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule